// File: doc/BRIEF.md
# Dual-Input Window Watchdog

This block supervises two independent periodic toggle signals, typically the heartbeat pins of two controllers. Each signal should spend roughly ten logic ticks high and ten low. The block advances only on a one-cycle `tick` strobe, which stands for the 1 kHz time base. Each input passes through a shift-register edge detector that acts on an edge three ticks after it happens, so any narrower pulse is ignored. The spacing between recognised edges is then compared against a closed window (the edge came too early) and an open window (the edge came too late).

Per channel, the block reports a window-violation flag. A combined `wd_ok` output is high only while both channels have recent valid edges and no fatal error is latched; downstream logic uses it to release the relay drivers and to put out the warning lamp. Each channel keeps a silence counter. When it runs past a long timeout, a sticky failure flag is set. That flag survives the ordinary supervision reset `rst_n` and is cleared only by the power-on reset `por_n`.

Top module: `wdw_dual_watchdog`

## Requirements
- R1: Each input is sampled on every tick. A new level is recognised as an edge on the third tick after the tick that first sampled it, provided it is held for at least SETTLE (3) samples. A level held for fewer samples produces no edge and changes no output.
- R2: After reset `wd_ok` and `fail_flag` are 0 and both channels are disarmed. A disarmed channel ignores rising edges and arms on its first falling edge. `wd_ok` rises with the tick on which the second channel arms. Inputs that start high therefore need one edge, and inputs that start low need two.
- R3: On an armed channel, an edge whose spacing from the previous edge or restart is below MIN_GAP ticks sets that channel's `win_err` bit and drops `wd_ok`.
- R4: On an armed channel, an edge with a spacing from MIN_GAP up to 15 ticks clears that channel's `win_err` bit and marks the channel valid.
- R5: When 16 ticks pass on a channel without an edge, a restart occurs on the 16th tick. It sets `win_err`, disarms the channel and drops `wd_ok`. Restarts repeat every 16 ticks. An edge on the same tick as a restart is overridden by the restart.
- R6: After a restart the channel recovers only through a new arming falling edge, as in R2.
- R7: A valid edge is an arming edge or an in-window edge. If more than TIMEOUT (120) ticks pass on a channel without one, `fail_flag` is set. While it is set, `wd_ok` is 0.
- R8: `fail_flag`, once set, stays set through any `rst_n` pulse and is cleared only by `por_n`.
- R9: The outputs change only as a result of a tick. Between ticks they hold.
- R10: The two channels are independent. Stimulus on one channel never changes the other channel's `win_err` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Supervision reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low; the only clear for `fail_flag` |
| tick | input | 1 | One-cycle logic time-base strobe |
| wd_in | input | NUM_CH | Watchdog toggle inputs, one bit per channel |
| win_err | output | NUM_CH | Per-channel window-violation flag |
| wd_ok | output | 1 | Both channels valid and no fatal error |
| fail_flag | output | 1 | Sticky long-silence failure flag |

## Verification
The bench builds the block with MIN_GAP = 5 and leaves all other parameters at their defaults. With the default closed window of 3, the three-sample edge filter already keeps edges at least three ticks apart, so the too-early branch could never fire. Raising MIN_GAP to 5 lets a toggle with a four-tick half period reach that branch. The default 16-tick restart and the 120-tick timeout are short enough that the bench can drive sustained silences into repeated restarts and then into the sticky failure.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    // Kind of edge reported by a detector for the current sample history
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_kind_e;

    // Alternating fill used as the detector's reset history: it can never
    // match a settled pattern, whatever level the input starts at.
    function automatic logic [63:0] alt_fill();
        return {32{2'b10}};
    endfunction

endpackage

// File: rtl/wdw_edge_det.sv
module wdw_edge_det
    import wdw_pkg::*;
#(
    parameter int SETTLE = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wd,
    output edge_kind_e kind
);
    localparam int HLEN = 2 * SETTLE;
    localparam logic [HLEN-1:0] RISE_PAT = {{SETTLE{1'b0}}, {SETTLE{1'b1}}};
    localparam logic [HLEN-1:0] FALL_PAT = ~RISE_PAT;
    localparam logic [63:0]     FILL_ALL = alt_fill();
    localparam logic [HLEN-1:0] IDLE_PAT = FILL_ALL[HLEN-1:0];

    typedef struct packed {
        logic [HLEN-1:0] hist;   // newest sample in bit 0
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d = det_q;
        if (tick) begin
            det_d.hist = {det_q.hist[HLEN-2:0], wd};
        end
        if (det_q.hist == RISE_PAT) begin
            kind = EDGE_RISE;
        end else if (det_q.hist == FALL_PAT) begin
            kind = EDGE_FALL;
        end else begin
            kind = EDGE_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q.hist <= IDLE_PAT;
        end else begin
            det_q <= det_d;
        end
    end

endmodule

// File: rtl/wdw_gap_chan.sv
module wdw_gap_chan
    import wdw_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int MIN_GAP = 3,
    parameter int TIMEOUT = 120
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  edge_kind_e kind,
    output logic       ch_ok,
    output logic       ch_viol,
    output logic       expired
);
    localparam int               SIL_W   = $clog2(TIMEOUT + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [SIL_W-1:0] SIL_TOP = SIL_W'(TIMEOUT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;      // ticks since last edge or restart
        logic             armed;
        logic             ok;
        logic             viol;
        logic [SIL_W-1:0] silence;  // ticks since last valid edge
    } gap_t;

    gap_t g_d, g_q;
    logic restart;
    logic edge_seen;
    logic good_edge;

    always_comb begin
        g_d       = g_q;
        restart   = tick && (g_q.cnt == CNT_MAX);
        edge_seen = tick && (kind != EDGE_NONE);
        good_edge = 1'b0;
        if (tick) begin
            g_d.cnt = g_q.cnt + 1'b1;
            if (restart) begin
                // dominant restart: window missed, fall back to start-up
                g_d.cnt   = '0;
                g_d.armed = 1'b0;
                g_d.ok    = 1'b0;
                g_d.viol  = 1'b1;
            end else if (edge_seen) begin
                g_d.cnt = '0;
                if (!g_q.armed) begin
                    if (kind == EDGE_FALL) begin
                        g_d.armed = 1'b1;
                        g_d.ok    = 1'b1;
                        g_d.viol  = 1'b0;
                        good_edge = 1'b1;
                    end
                end else if ((int'(g_q.cnt) + 1) < MIN_GAP) begin
                    g_d.ok   = 1'b0;
                    g_d.viol = 1'b1;
                end else begin
                    g_d.ok    = 1'b1;
                    g_d.viol  = 1'b0;
                    good_edge = 1'b1;
                end
            end
            if (good_edge) begin
                g_d.silence = '0;
            end else if (g_q.silence != SIL_TOP) begin
                g_d.silence = g_q.silence + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign ch_ok   = g_q.ok;
    assign ch_viol = g_q.viol;
    assign expired = (g_q.silence == SIL_TOP);

endmodule

// File: rtl/wdw_dual_watchdog.sv
module wdw_dual_watchdog
    import wdw_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int SETTLE  = 3,
    parameter int CNT_W   = 4,
    parameter int MIN_GAP = 3,
    parameter int TIMEOUT = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              tick,
    input  logic [NUM_CH-1:0] wd_in,
    output logic [NUM_CH-1:0] win_err,
    output logic              wd_ok,
    output logic              fail_flag
);
    logic [NUM_CH-1:0] ch_ok;
    logic [NUM_CH-1:0] ch_exp;

    typedef struct packed {
        logic fail;
    } top_t;

    top_t t_d, t_q;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        edge_kind_e kind;

        wdw_edge_det #(
            .SETTLE (SETTLE)
        ) u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .wd    (wd_in[ch]),
            .kind  (kind)
        );

        wdw_gap_chan #(
            .CNT_W   (CNT_W),
            .MIN_GAP (MIN_GAP),
            .TIMEOUT (TIMEOUT)
        ) u_gap (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .kind    (kind),
            .ch_ok   (ch_ok[ch]),
            .ch_viol (win_err[ch]),
            .expired (ch_exp[ch])
        );
    end

    always_comb begin
        t_d = t_q;
        if (tick && rst_n && (|ch_exp)) begin
            t_d.fail = 1'b1;
        end
    end

    // Failure flag lives in the power-on domain only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign fail_flag = t_q.fail;
    assign wd_ok     = (&ch_ok) & ~t_q.fail;

endmodule

// File: rtl/wdw_dual_watchdog_chk.sv
module wdw_dual_watchdog_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic              tick,
    input logic [NUM_CH-1:0] win_err,
    input logic              wd_ok,
    input logic              fail_flag
);
    // R7: a latched failure always blocks the combined OK
    a_r7_fail_blocks_ok: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        fail_flag |-> !wd_ok);

    // R7: the failure flag can only rise as a result of a tick
    a_r7_fail_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $rose(fail_flag) |-> $past(tick));

    // R8: nothing but the power-on reset clears the failure flag
    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!por_n)
        fail_flag |=> fail_flag);

    // R3: a combined OK never coexists with a window violation
    a_r3_ok_excludes_viol: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        wd_ok |-> (win_err == '0));

    // R9: outputs hold across a clock without tick
    a_r9_quiet_between_ticks: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !tick |=> ($stable(wd_ok) && $stable(win_err) && $stable(fail_flag)));

    // R2: OK rises only right after a tick
    a_r2_ok_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $rose(wd_ok) |-> $past(tick));
endmodule

bind wdw_dual_watchdog wdw_dual_watchdog_chk #(
    .NUM_CH (NUM_CH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_n     (por_n),
    .tick      (tick),
    .win_err   (win_err),
    .wd_ok     (wd_ok),
    .fail_flag (fail_flag)
);

// File: tb/wdw_dual_watchdog_bench.sv
module wdw_dual_watchdog_bench;
    localparam int MIN_GAP = 5;
    localparam int TIMEOUT = 120;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] wd_in = 2'b11;
    logic [1:0] win_err;
    logic       wd_ok;
    logic       fail_flag;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdw_dual_watchdog #(
        .MIN_GAP (MIN_GAP),
        .TIMEOUT (TIMEOUT)
    ) u_wdw_dual_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_n     (por_n),
        .tick      (tick),
        .wd_in     (wd_in),
        .win_err   (win_err),
        .wd_ok     (wd_ok),
        .fail_flag (fail_flag)
    );

    // ---------------- requirement model ----------------
    logic [5:0] m_hist [2];
    int         m_since [2];
    bit         m_armed [2];
    bit         m_ok [2];
    bit         m_viol [2];
    int         m_sil [2];
    bit         m_fail;

    // generator
    int  hp [2];
    int  left [2];
    bit  rnd_mode = 1'b0;

    task automatic model_reset(input bit por);
        for (int c = 0; c < 2; c++) begin
            m_hist[c]  = 6'b101010;
            m_since[c] = 0;
            m_armed[c] = 0;
            m_ok[c]    = 0;
            m_viol[c]  = 0;
            m_sil[c]   = 0;
        end
        if (por) m_fail = 0;
    endtask

    task automatic model_tick();
        bit expire = 0;
        for (int c = 0; c < 2; c++) begin
            bit rise = (m_hist[c] == 6'b000111);
            bit fall = (m_hist[c] == 6'b111000);
            bit good = 0;
            int gap  = m_since[c] + 1;
            if (m_sil[c] >= TIMEOUT) expire = 1;
            if (gap == 16) begin
                m_armed[c] = 0; m_ok[c] = 0; m_viol[c] = 1; m_since[c] = 0;
            end else if (rise || fall) begin
                m_since[c] = 0;
                if (!m_armed[c]) begin
                    if (fall) begin
                        m_armed[c] = 1; m_ok[c] = 1; m_viol[c] = 0; good = 1;
                    end
                end else if (gap < MIN_GAP) begin
                    m_ok[c] = 0; m_viol[c] = 1;
                end else begin
                    m_ok[c] = 1; m_viol[c] = 0; good = 1;
                end
            end else begin
                m_since[c] = m_since[c] + 1;
            end
            if (good) m_sil[c] = 0;
            else if (m_sil[c] < TIMEOUT) m_sil[c] = m_sil[c] + 1;
            m_hist[c] = {m_hist[c][4:0], wd_in[c]};
        end
        if (expire) m_fail = 1;
    endtask

    function automatic bit exp_ok();
        return m_ok[0] && m_ok[1] && !m_fail;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, "wd_ok", int'(wd_ok), int'(exp_ok()));
        chk(req, "win_err", int'(win_err), int'({m_viol[1], m_viol[0]}));
        chk(req, "fail_flag", int'(fail_flag), int'(m_fail));
    endtask

    task automatic gen_update();
        for (int c = 0; c < 2; c++) begin
            if (hp[c] != 0) begin
                left[c] = left[c] - 1;
                if (left[c] <= 0) begin
                    wd_in[c] = ~wd_in[c];
                    if (rnd_mode) hp[c] = 3 + int'($urandom_range(14));
                    left[c] = hp[c];
                end
            end
        end
    endtask

    // one tick: drive inputs, strobe, compare, then verify the outputs hold
    task automatic step(input string req);
        @(negedge clk);
        gen_update();
        tick = 1'b1;
        model_tick();
        @(negedge clk);
        tick = 1'b0;
        compare_all(req);
        repeat (3) @(negedge clk);
        chk("R9", "wd_ok between ticks", int'(wd_ok), int'(exp_ok()));
    endtask

    task automatic set_gen(input int c, input int h);
        hp[c]   = h;
        left[c] = h;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit [31:0] seed_dummy;
        seed_dummy = $urandom(32'd1234);
        model_reset(1);
        set_gen(0, 0);
        set_gen(1, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        por_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk("R2", "reset wd_ok", int'(wd_ok), 0);
        chk("R2", "reset win_err", int'(win_err), 0);
        chk("R2", "reset fail_flag", int'(fail_flag), 0);

        // R1/R2: both inputs start high, drop together; OK after third tick
        repeat (5) step("R2");
        @(negedge clk);
        wd_in = 2'b00;
        for (int i = 1; i <= 4; i++) begin
            step("R1");
            chk("R1", "ok timing after fall", int'(wd_ok), (i == 4) ? 1 : 0);
        end

        // R4: both toggling with 10-tick halves
        set_gen(0, 10);
        set_gen(1, 10);
        repeat (50) step("R4");
        chk("R4", "steady ok", int'(wd_ok), 1);

        // R1: two-sample glitch on channel 0 is ignored
        set_gen(0, 0);
        wd_in[0] = ~wd_in[0];
        step("R1");
        step("R1");
        wd_in[0] = ~wd_in[0];
        repeat (4) step("R1");
        chk("R1", "glitch no error", int'(win_err[0]), 0);
        set_gen(0, 10);
        repeat (20) step("R4");

        // R3: channel 1 toggles too fast; R10 channel 0 unaffected
        set_gen(1, 4);
        repeat (20) step("R3");
        chk("R3", "early violation ch1", int'(win_err[1]), 1);
        chk("R10", "ch0 independent", int'(win_err[0]), 0);
        chk("R3", "ok dropped", int'(wd_ok), 0);
        set_gen(1, 10);
        repeat (30) step("R4");
        chk("R4", "recovered", int'(wd_ok), 1);

        // R5/R6: channel 0 silent for 40 ticks then resumes
        set_gen(0, 0);
        repeat (40) step("R5");
        chk("R5", "restart violation", int'(win_err[0]), 1);
        chk("R10", "ch1 independent", int'(win_err[1]), 0);
        set_gen(0, 10);
        repeat (40) step("R6");
        chk("R6", "rearmed", int'(wd_ok), 1);

        // R10: random half periods, straddling both windows
        rnd_mode = 1'b1;
        repeat (300) step("R10");
        rnd_mode = 1'b0;

        // R7: both silent long enough for the timeout
        set_gen(0, 0);
        set_gen(1, 0);
        repeat (130) step("R7");
        chk("R7", "fail set", int'(fail_flag), 1);
        chk("R7", "ok blocked", int'(wd_ok), 0);

        // R8: supervision reset does not clear the failure
        @(negedge clk);
        rst_n = 1'b0;
        model_reset(0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "fail survives rst_n", int'(fail_flag), 1);
        set_gen(0, 10);
        set_gen(1, 10);
        repeat (30) step("R8");
        chk("R8", "ok held low by fail", int'(wd_ok), 0);

        // R8: power-on reset clears it
        @(negedge clk);
        rst_n = 1'b0;
        por_n = 1'b0;
        model_reset(1);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        por_n = 1'b1;
        @(negedge clk);
        chk("R8", "por clears fail", int'(fail_flag), 0);
        repeat (40) step("R4");
        chk("R4", "ok after por", int'(wd_ok), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule